// File: doc/BRIEF.md
# Direction Counter Table With Target-Cache Override

This block is the direction half of a fetch-stage branch predictor. It holds a direct-mapped array of 2-bit saturating counters. Each counter summarises the recent taken/not-taken behaviour of the branches whose addresses fall on its slot. Every fetch address looks up one counter. Alongside that lookup, a separate target cache reports whether it holds an entry for the same address. The target cache on its own would treat any hit as a taken branch.

The counter's verdict outranks that guess. When the target cache hits but the counter says not-taken, the block issues a corrective redirect one cycle after the lookup, pointing fetch at the sequential address (fetch address plus 4). When the counter says taken but the target cache missed, no target is known, so the block leaves the fetch stream alone.

When a branch resolves in execute, its address and outcome arrive on a resolution port and move the matching counter one step toward that outcome. Slots carry no tag, so branches that share index bits share a counter.

Top module: `dirpred_override`

## Requirements
- R1: After synchronous reset every counter holds 01 (weakly not-taken), and the block drives pred_valid=0 and redirect_valid=0 until a lookup is made.
- R2: The counter slot is selected by address bits [10:2] only. Addresses that differ only in bits [1:0] or in bits above 10 read and update the same counter, with no tag compare.
- R3: A lookup presented with fetch_valid=1 yields pred_valid=1 in the next cycle. In that cycle pred_taken equals bit 1 of the counter (1 = taken).
- R4: A resolution with res_taken=1 raises the counter by one, stopping at 11.
- R5: A resolution with res_taken=0 lowers the counter by one, stopping at 00.
- R6: If the lookup had tc_hit=1 and the counter predicts not-taken, then in the next cycle redirect_valid=1 and redirect_addr equals the looked-up fetch_addr plus 4.
- R7: No redirect is issued when the counter predicts taken, whether tc_hit is 1 or 0. No redirect is issued when tc_hit=0 and the counter predicts not-taken.
- R8: When a lookup and a resolution address the same counter in the same cycle, the lookup sees the counter value from before that update. The update still takes effect for later lookups.
- R9: A cycle with fetch_valid=0 produces pred_valid=0 and redirect_valid=0 in the next cycle, and a cycle with res_valid=0 changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch address is presented for lookup |
| fetch_addr | input | ADDR_W | Fetch address being looked up |
| tc_hit | input | 1 | Target cache hit for this fetch address (hit implies taken to the target cache) |
| res_valid | input | 1 | A branch resolved in execute this cycle |
| res_addr | input | ADDR_W | Address of the resolved branch |
| res_taken | input | 1 | Resolved outcome, 1 = taken |
| pred_valid | output | 1 | Direction prediction for the previous cycle's lookup is valid |
| pred_taken | output | 1 | Counter direction prediction, 1 = taken |
| redirect_valid | output | 1 | Corrective redirect request |
| redirect_addr | output | ADDR_W | Corrected fetch address (looked-up address plus 4) |

## Verification
A lookup and a counter update can land on the same slot in the same cycle. The outcome then depends on whether the read sees the pre-update or the post-update counter. The bench provokes this both with directed cycles that place the fetch and resolution addresses on one index, and with random traffic drawn from a small pool of indices so that collisions, including aliases that differ only in high bits, occur often. Each prediction and redirect is judged against a bench-side counter array. That array returns the old value for a same-cycle collision and applies the update afterwards.

// File: rtl/dpo_pkg.sv
package dpo_pkg;
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_INIT = 2'b01;
  localparam ctr_t CTR_MAX  = 2'b11;
  localparam ctr_t CTR_MIN  = 2'b00;

  // One saturating step toward the resolved outcome
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_MAX) ? cur : cur + ctr_t'(1);
    else       nxt = (cur == CTR_MIN) ? cur : cur - ctr_t'(1);
    return nxt;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t c);
    return c[CTR_W-1];
  endfunction
endpackage

// File: rtl/dpo_counter_table.sv
module dpo_counter_table
  import dpo_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];
  ctr_t rd_q;

  // Read port: registered, read-before-write on a same-index collision
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= CTR_INIT;
    end else if (rd_en) begin
      rd_q <= mem[rd_idx];
    end
  end

  // Update port: read-modify-write of one slot per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= ctr_step(mem[wr_idx], wr_taken);
    end
  end

  assign rd_ctr = rd_q;
endmodule

// File: rtl/dpo_lookup_pipe.sv
module dpo_lookup_pipe #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_hit,
  output logic              q_valid,
  output logic [ADDR_W-1:0] q_addr,
  output logic              q_hit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_addr  <= '0;
      q_hit   <= 1'b0;
    end else begin
      q_valid <= in_valid;
      q_hit   <= in_valid & in_hit;
      if (in_valid) q_addr <= in_addr;
    end
  end
endmodule

// File: rtl/dpo_override.sv
module dpo_override
  import dpo_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SEQ_INC = 4
) (
  input  logic              look_valid,
  input  logic [ADDR_W-1:0] look_addr,
  input  logic              look_hit,
  input  ctr_t              look_ctr,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_addr
);
  logic ctr_taken;

  always_comb begin
    ctr_taken      = ctr_says_taken(look_ctr);
    pred_valid     = look_valid;
    pred_taken     = look_valid & ctr_taken;
    // Target cache implied taken, counter disagrees: fall back to sequential
    redirect_valid = look_valid & look_hit & ~ctr_taken;
    redirect_addr  = look_addr + ADDR_W'(SEQ_INC);
  end
endmodule

// File: rtl/dirpred_override.sv
module dirpred_override
  import dpo_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_LSB = 2,
  parameter int IDX_W   = 9,
  parameter int SEQ_INC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              tc_hit,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_addr,
  input  logic              res_taken,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_addr
);
  localparam int IDX_HI = IDX_LSB + IDX_W - 1;

  logic [IDX_W-1:0]  f_idx, r_idx;
  ctr_t              look_ctr;
  logic              look_valid, look_hit;
  logic [ADDR_W-1:0] look_addr;

  assign f_idx = fetch_addr[IDX_HI:IDX_LSB];
  assign r_idx = res_addr[IDX_HI:IDX_LSB];

  // Resolution address bits outside the index carry no information here
  generate
    if (IDX_LSB > 0 && IDX_HI < ADDR_W - 1) begin : g_unused_both
      logic res_unused_bits;
      assign res_unused_bits = ^{res_addr[ADDR_W-1:IDX_HI+1], res_addr[IDX_LSB-1:0]};
    end else if (IDX_LSB > 0) begin : g_unused_low
      logic res_unused_bits;
      assign res_unused_bits = ^res_addr[IDX_LSB-1:0];
    end else if (IDX_HI < ADDR_W - 1) begin : g_unused_high
      logic res_unused_bits;
      assign res_unused_bits = ^res_addr[ADDR_W-1:IDX_HI+1];
    end
  endgenerate

  dpo_counter_table #(.IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (fetch_valid),
    .rd_idx   (f_idx),
    .rd_ctr   (look_ctr),
    .wr_en    (res_valid),
    .wr_idx   (r_idx),
    .wr_taken (res_taken)
  );

  dpo_lookup_pipe #(.ADDR_W(ADDR_W)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .in_valid (fetch_valid),
    .in_addr  (fetch_addr),
    .in_hit   (tc_hit),
    .q_valid  (look_valid),
    .q_addr   (look_addr),
    .q_hit    (look_hit)
  );

  dpo_override #(.ADDR_W(ADDR_W), .SEQ_INC(SEQ_INC)) u_ovr (
    .look_valid     (look_valid),
    .look_addr      (look_addr),
    .look_hit       (look_hit),
    .look_ctr       (look_ctr),
    .pred_valid     (pred_valid),
    .pred_taken     (pred_taken),
    .redirect_valid (redirect_valid),
    .redirect_addr  (redirect_addr)
  );
endmodule

// File: rtl/dirpred_override_chk.sv
module dirpred_override_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              tc_hit,
  input logic              pred_valid,
  input logic              pred_taken,
  input logic              redirect_valid,
  input logic [ADDR_W-1:0] redirect_addr
);
  // R3 / R9: a lookup always produces a prediction next cycle
  a_r3_pred_follows_lookup: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> pred_valid);

  // R9: no lookup, no prediction and no redirect
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> (!pred_valid && !redirect_valid));

  // R6: redirect targets the sequential address of the looked-up fetch
  a_r6_redirect_addr: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> (!redirect_valid || redirect_addr == $past(fetch_addr) + ADDR_W'(4)));

  // R6: a target cache hit ends either as a taken prediction or as a redirect
  a_r6_hit_resolved: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && tc_hit) |=> (pred_taken != redirect_valid));

  // R7: a miss never redirects
  a_r7_miss_no_redirect: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !tc_hit) |=> !redirect_valid);

  // R7: a redirect only accompanies a valid not-taken prediction
  a_r7_redirect_only_nt: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> (pred_valid && !pred_taken));
endmodule

bind dirpred_override dirpred_override_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .fetch_valid    (fetch_valid),
  .fetch_addr     (fetch_addr),
  .tc_hit         (tc_hit),
  .pred_valid     (pred_valid),
  .pred_taken     (pred_taken),
  .redirect_valid (redirect_valid),
  .redirect_addr  (redirect_addr)
);

// File: tb/dirpred_override_test.sv
`timescale 1ns/1ps
module dirpred_override_test;
  localparam int AW = 32;
  localparam int NIDX = 512;

  logic clk = 1'b0;
  logic rst;
  logic fetch_valid, tc_hit, res_valid, res_taken;
  logic [AW-1:0] fetch_addr, res_addr;
  logic pred_valid, pred_taken, redirect_valid;
  logic [AW-1:0] redirect_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [1:0] model [NIDX];

  always #2 clk = ~clk;

  dirpred_override uut (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .tc_hit(tc_hit),
    .res_valid(res_valid), .res_addr(res_addr), .res_taken(res_taken),
    .pred_valid(pred_valid), .pred_taken(pred_taken),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr)
  );

  function automatic int idx_of(input logic [AW-1:0] a);
    return int'(a[10:2]);
  endfunction

  function automatic logic [1:0] step(input logic [1:0] c, input logic t);
    if (t) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle at a negedge, then check the outputs at the next negedge
  task automatic cyc(input logic fv, input logic [AW-1:0] fa, input logic hit,
                     input logic rv, input logic [AW-1:0] ra, input logic rt,
                     input string req);
    logic [1:0] c;
    logic ep, er;
    fetch_valid = fv; fetch_addr = fa; tc_hit = hit;
    res_valid = rv; res_addr = ra; res_taken = rt;
    c  = model[idx_of(fa)];
    ep = fv & c[1];
    er = fv & hit & ~c[1];
    if (rv) model[idx_of(ra)] = step(model[idx_of(ra)], rt);
    @(negedge clk);
    check({req, " pred_valid"},     AW'(pred_valid),     AW'(fv));
    check({req, " pred_taken"},     AW'(pred_taken),     AW'(ep));
    check({req, " redirect_valid"}, AW'(redirect_valid), AW'(er));
    if (er) check({req, " redirect_addr"}, redirect_addr, fa + 32'd4);
  endtask

  task automatic upd(input logic [AW-1:0] ra, input logic rt, input string req);
    cyc(1'b0, '0, 1'b0, 1'b1, ra, rt, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < NIDX; i++) model[i] = 2'b01;
    rst = 1'b1; fetch_valid = 0; fetch_addr = '0; tc_hit = 0;
    res_valid = 0; res_addr = '0; res_taken = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: quiet outputs right after reset
    check("R1 pred_valid after reset", AW'(pred_valid), '0);
    check("R1 redirect_valid after reset", AW'(redirect_valid), '0);
    // R1: weakly not-taken everywhere, so a hit is overridden (R6)
    cyc(1, 32'h0000_0100, 1, 0, '0, 0, "R1_R6 init hit");
    cyc(1, 32'h0000_07FC, 0, 0, '0, 0, "R1_R7 init miss");
    // R9: idle cycle
    cyc(0, 32'h0000_0100, 1, 0, '0, 0, "R9 idle");
    // R4: three taken then two not-taken on index 0x10
    for (int k = 0; k < 3; k++) upd(32'h0000_0040, 1, "R4 inc");
    cyc(1, 32'h0000_0040, 0, 0, '0, 0, "R4_R7 taken miss");
    cyc(1, 32'h0000_0040, 1, 0, '0, 0, "R4_R7 taken hit");
    upd(32'h0000_0040, 0, "R4 dec");
    upd(32'h0000_0040, 0, "R4 dec");
    cyc(1, 32'h0000_0040, 1, 0, '0, 0, "R4 saturated then down");
    // R5: three not-taken then one taken on index 0x20
    for (int k = 0; k < 3; k++) upd(32'h0000_0080, 0, "R5 dec");
    upd(32'h0000_0080, 1, "R5 inc");
    cyc(1, 32'h0000_0080, 1, 0, '0, 0, "R5 saturated then up");
    // R2: alias through high and low bits
    upd(32'hABC0_08C1, 1, "R2 alias upd");
    cyc(1, 32'h0000_00C2, 1, 0, '0, 0, "R2 alias lookup");
    // R8: same-cycle collision, read sees old value, update persists
    cyc(1, 32'h0000_00C0, 1, 1, 32'h0000_00C0, 1, "R8 collide");
    cyc(1, 32'h0000_00C0, 1, 0, '0, 0, "R8 after collide");
    // Random traffic over a small index pool to force collisions
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] fa, ra;
      fa = {$urandom() % 32'h1000, 2'b00} & 32'h0000_003C | ($urandom() & 32'hFFFF_F803);
      ra = ($urandom() % 4 == 0) ? fa ^ 32'h0000_0800
                                  : (($urandom() & 32'h0000_003C) | ($urandom() & 32'hFFFF_F803));
      cyc($urandom() % 8 != 0, fa, $urandom() % 2, $urandom() % 3 != 0, ra,
          $urandom() % 2, "R3_R6_R7_R8 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule